// File: doc/BRIEF.md
# Pixel Output Formatter with Power-Down Gating

This block sits at the output edge of a video receiver. It takes 24-bit pixels with a data-enable and a small set of control bits, and places them on two output buses, an even bus and an odd bus. In one-pixel mode each accepted pixel goes straight to the even bus, and the odd bus is disabled. In two-pixel mode a small state machine pairs consecutive accepted pixels. The first pixel of a pair goes to the even bus and the second to the odd bus, with a one-cycle output data-enable for each pair. In two-pixel mode the odd bus can be staggered by half a clock. The forwarded output clock can be inverted, but never while dual-link operation is selected. A link monitor raises a sync-detect flag while the data-enable keeps changing.

Two active-low power-down inputs drive a registered enable flag for each output. A disabled output shows zeros, which stands in for a pull-down. Output power-down turns off every output except sync-detect and control bit 1, and the logic inside keeps running. Full power-down turns off every output and freezes all internal state, so the inputs have no effect until it is released.

The pairing machine has two states. In `ST_IDLE` no pixel is pending. In `ST_HALF` the first pixel of a pair is held. It has these transitions:
- `ST_IDLE`→`ST_HALF` when two-pixel mode is on and a pixel is accepted.
- `ST_HALF`→`ST_IDLE` on a completed pair, when the second pixel is accepted.
- `ST_HALF`→`ST_IDLE` on a flush, when data-enable is low.
- `ST_HALF`→`ST_IDLE` on a mode drop, when two-pixel mode is turned off and the pending pixel is discarded.
- `ST_IDLE`→`ST_IDLE` in one-pixel mode, or when no pixel arrives.

Top module: `pixel_out_fmt`

## Requirements
- R1: While reset is low, every data output, data-enable, control output, clock output, sync-detect output and every enable flag reads 0.
- R2: With `two_pix_i`=0, the pixel and data-enable at one rising edge appear on `even_o`/`de_o` after that edge. `odd_oe_o` is 0 and `odd_o` reads 0.
- R3: With `two_pix_i`=1, the first accepted pixel is held. When the second is accepted, `even_o` shows the first, `odd_o` shows the second, and `de_o` is 1 for exactly one cycle. `de_o` is 0 in every other cycle.
- R4: In two-pixel mode, if data-enable is low while a first pixel is pending, the pair is still emitted with `de_o`=1. `even_o` shows the pending pixel and `odd_o` keeps its previous value.
- R5: Staggering is active only when `two_pix_i`=1 and `stag_n_i`=0. The odd bus then updates on the falling edge, so during the high clock phase `odd_o` still shows the value from before the latest rising edge. Otherwise both buses update together.
- R6: `oclk_o` equals `clk` when normal and its inverse when inverted (`clk_inv_i`=1). Data outputs are unaffected.
- R7: While `dual_link_i`=1, clock inversion is refused and `oclk_o` has normal polarity.
- R8: With `out_pd_n_i`=0 and `full_pd_n_i`=1, only `sync_oe_o` and `ctl_oe_o[1]` stay 1. All other outputs read 0, and pairing and monitoring keep running.
- R9: With `full_pd_n_i`=0, all enable flags are 0 and all outputs read 0. Internal state is frozen and resumes unchanged on release, including a pending half pair.
- R10: `sync_det_o` goes to 1 one cycle after data-enable changes. It falls to 0 once `SYNC_LIMIT` (default 8) edges pass without a change. After reset it is 0.
- R11: `ctl_o` shows `ctl_i` one rising edge later in both pixel modes.
- R12: Turning off two-pixel mode while a pixel is pending discards that pixel. The current input is handled as one-pixel data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_i | input | 24 | Incoming pixel |
| de_i | input | 1 | Incoming data-enable |
| ctl_i | input | 4 | Incoming control bits |
| two_pix_i | input | 1 | 1 = two pixels per clock |
| stag_n_i | input | 1 | 0 = stagger odd bus (two-pixel mode only) |
| clk_inv_i | input | 1 | 1 = request inverted output clock |
| dual_link_i | input | 1 | 1 = dual-link mode, blocks inversion |
| out_pd_n_i | input | 1 | Active-low output power-down |
| full_pd_n_i | input | 1 | Active-low full power-down |
| even_o | output | 24 | Even (first) pixel bus |
| odd_o | output | 24 | Odd (second) pixel bus |
| de_o | output | 1 | Output data-enable |
| ctl_o | output | 4 | Output control bits |
| oclk_o | output | 1 | Forwarded output clock |
| sync_det_o | output | 1 | Link activity flag |
| even_oe_o | output | 1 | Even bus enable |
| odd_oe_o | output | 1 | Odd bus enable |
| de_oe_o | output | 1 | Data-enable output enable |
| ctl_oe_o | output | 4 | Per-bit control output enables |
| oclk_oe_o | output | 1 | Clock output enable |
| sync_oe_o | output | 1 | Sync-detect output enable |

## Verification
The assertions check the following on every cycle:
- the enable pattern for each power-down level;
- that the odd enable is off in one-pixel mode;
- that `ST_HALF` never lasts two running cycles;
- that full power-down freezes state;
- that inversion is refused under dual-link.

The bench scenarios are needed for the rest. They cover data placement on the buses, the odd-count flush, the half-cycle stagger, the clock polarity seen at the pin, the sync-detect timeout, and the loss of a pending pixel when two-pixel mode drops mid-pair.

// File: rtl/pof_pkg.sv
package pof_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HALF = 1'b1
    } pair_state_e;
endpackage

// File: rtl/pof_pair_fsm.sv
module pof_pair_fsm
    import pof_pkg::*;
#(
    parameter int PIX_W = 24,
    parameter int CTL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             two_pix,
    input  logic [PIX_W-1:0] pix,
    input  logic             de,
    input  logic [CTL_W-1:0] ctl,
    output logic [PIX_W-1:0] even_q,
    output logic [PIX_W-1:0] odd_q,
    output logic             de_q,
    output logic [CTL_W-1:0] ctl_q,
    output pair_state_e      state_q
);
    pair_state_e      state_nx;
    logic [PIX_W-1:0] first_q, first_nx, even_nx, odd_nx;
    logic             de_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state_q <= ST_IDLE;
        else if (run) state_q <= state_nx;
    end

    // next state and next output values
    always_comb begin
        state_nx = state_q;
        first_nx = first_q;
        even_nx  = even_q;
        odd_nx   = odd_q;
        de_nx    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (two_pix) begin
                    if (de) begin
                        first_nx = pix;
                        state_nx = ST_HALF;
                    end
                end else begin
                    even_nx = pix;
                    de_nx   = de;
                end
            end
            ST_HALF: begin
                state_nx = ST_IDLE;
                if (!two_pix) begin
                    even_nx = pix;
                    de_nx   = de;
                end else begin
                    even_nx = first_q;
                    de_nx   = 1'b1;
                    if (de) odd_nx = pix;
                end
            end
        endcase
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q <= '0;
            even_q  <= '0;
            odd_q   <= '0;
            de_q    <= 1'b0;
            ctl_q   <= '0;
        end else if (run) begin
            first_q <= first_nx;
            even_q  <= even_nx;
            odd_q   <= odd_nx;
            de_q    <= de_nx;
            ctl_q   <= ctl;
        end
    end
endmodule

// File: rtl/pof_link_mon.sv
module pof_link_mon #(
    parameter int SYNC_LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic de,
    output logic sync_det
);
    localparam int CW = $clog2(SYNC_LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(SYNC_LIMIT);

    logic [CW-1:0] cnt_q;
    logic          de_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= LIM;
            de_prev_q <= 1'b0;
        end else if (run) begin
            de_prev_q <= de;
            if (de != de_prev_q)  cnt_q <= '0;
            else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign sync_det = (cnt_q != LIM);
endmodule

// File: rtl/pof_oe_ctrl.sv
module pof_oe_ctrl #(
    parameter int CTL_W    = 4,
    parameter int CTL1_IDX = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             full_pd_n,
    input  logic             out_pd_n,
    input  logic             two_pix,
    input  logic             stag_n,
    input  logic             clk_inv,
    input  logic             dual_link,
    output logic             even_oe,
    output logic             odd_oe,
    output logic             de_oe,
    output logic [CTL_W-1:0] ctl_oe,
    output logic             oclk_oe,
    output logic             sync_oe,
    output logic             inv_q,
    output logic             stag_q
);
    logic             drv_on;
    logic [CTL_W-1:0] ctl_oe_nx;

    assign drv_on = full_pd_n & out_pd_n;

    for (genvar i = 0; i < CTL_W; i++) begin : g_ctl_oe
        if (i == CTL1_IDX) begin : g_exempt
            assign ctl_oe_nx[i] = full_pd_n;
        end else begin : g_plain
            assign ctl_oe_nx[i] = drv_on;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            even_oe <= 1'b0;
            odd_oe  <= 1'b0;
            de_oe   <= 1'b0;
            ctl_oe  <= '0;
            oclk_oe <= 1'b0;
            sync_oe <= 1'b0;
        end else begin
            even_oe <= drv_on;
            odd_oe  <= drv_on & two_pix;
            de_oe   <= drv_on;
            ctl_oe  <= ctl_oe_nx;
            oclk_oe <= drv_on;
            sync_oe <= full_pd_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inv_q  <= 1'b0;
            stag_q <= 1'b0;
        end else if (full_pd_n) begin
            inv_q  <= clk_inv & ~dual_link;
            stag_q <= two_pix & ~stag_n;
        end
    end
endmodule

// File: rtl/pof_odd_stagger.sv
module pof_odd_stagger #(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stag,
    input  logic [PIX_W-1:0] odd_in,
    output logic [PIX_W-1:0] odd_out
);
    logic [PIX_W-1:0] odd_neg_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) odd_neg_q <= '0;
        else        odd_neg_q <= odd_in;
    end

    assign odd_out = stag ? odd_neg_q : odd_in;
endmodule

// File: rtl/pixel_out_fmt.sv
module pixel_out_fmt
    import pof_pkg::*;
#(
    parameter int PIX_W      = 24,
    parameter int CTL_W      = 4,
    parameter int CTL1_IDX   = 1,
    parameter int SYNC_LIMIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix_i,
    input  logic             de_i,
    input  logic [CTL_W-1:0] ctl_i,
    input  logic             two_pix_i,
    input  logic             stag_n_i,
    input  logic             clk_inv_i,
    input  logic             dual_link_i,
    input  logic             out_pd_n_i,
    input  logic             full_pd_n_i,
    output logic [PIX_W-1:0] even_o,
    output logic [PIX_W-1:0] odd_o,
    output logic             de_o,
    output logic [CTL_W-1:0] ctl_o,
    output logic             oclk_o,
    output logic             sync_det_o,
    output logic             even_oe_o,
    output logic             odd_oe_o,
    output logic             de_oe_o,
    output logic [CTL_W-1:0] ctl_oe_o,
    output logic             oclk_oe_o,
    output logic             sync_oe_o
);
    pair_state_e      pair_state;
    logic [PIX_W-1:0] even_q, odd_q, odd_shown;
    logic             de_q, sync_raw, inv_q, stag_q;
    logic [CTL_W-1:0] ctl_q;

    pof_pair_fsm #(.PIX_W(PIX_W), .CTL_W(CTL_W)) u_pair (
        .clk(clk), .rst_n(rst_n), .run(full_pd_n_i), .two_pix(two_pix_i),
        .pix(pix_i), .de(de_i), .ctl(ctl_i),
        .even_q(even_q), .odd_q(odd_q), .de_q(de_q), .ctl_q(ctl_q),
        .state_q(pair_state)
    );

    pof_link_mon #(.SYNC_LIMIT(SYNC_LIMIT)) u_mon (
        .clk(clk), .rst_n(rst_n), .run(full_pd_n_i), .de(de_i),
        .sync_det(sync_raw)
    );

    pof_oe_ctrl #(.CTL_W(CTL_W), .CTL1_IDX(CTL1_IDX)) u_oe (
        .clk(clk), .rst_n(rst_n), .full_pd_n(full_pd_n_i), .out_pd_n(out_pd_n_i),
        .two_pix(two_pix_i), .stag_n(stag_n_i), .clk_inv(clk_inv_i),
        .dual_link(dual_link_i),
        .even_oe(even_oe_o), .odd_oe(odd_oe_o), .de_oe(de_oe_o),
        .ctl_oe(ctl_oe_o), .oclk_oe(oclk_oe_o), .sync_oe(sync_oe_o),
        .inv_q(inv_q), .stag_q(stag_q)
    );

    pof_odd_stagger #(.PIX_W(PIX_W)) u_stag (
        .clk(clk), .rst_n(rst_n), .stag(stag_q), .odd_in(odd_q),
        .odd_out(odd_shown)
    );

    // disabled outputs read as zero
    assign even_o     = even_oe_o ? even_q    : '0;
    assign odd_o      = odd_oe_o  ? odd_shown : '0;
    assign de_o       = de_oe_o & de_q;
    assign ctl_o      = ctl_oe_o & ctl_q;
    assign sync_det_o = sync_oe_o & sync_raw;
    assign oclk_o     = oclk_oe_o & (clk ^ inv_q);
endmodule

// File: rtl/pixel_out_fmt_chk.sv
module pixel_out_fmt_chk
    import pof_pkg::*;
#(
    parameter int PIX_W    = 24,
    parameter int CTL_W    = 4,
    parameter int CTL1_IDX = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             two_pix_i,
    input logic             dual_link_i,
    input logic             out_pd_n_i,
    input logic             full_pd_n_i,
    input logic             even_oe_o,
    input logic             odd_oe_o,
    input logic             de_oe_o,
    input logic [CTL_W-1:0] ctl_oe_o,
    input logic             oclk_oe_o,
    input logic             sync_oe_o,
    input pair_state_e      pair_state,
    input logic [PIX_W-1:0] even_q,
    input logic             inv_q
);
    // R9
    full_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !full_pd_n_i |=> (!even_oe_o && !odd_oe_o && !de_oe_o && ctl_oe_o == '0
                          && !oclk_oe_o && !sync_oe_o));

    // R8
    outpd_exempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_pd_n_i && !out_pd_n_i) |=> (sync_oe_o && ctl_oe_o[CTL1_IDX]
                          && !even_oe_o && !odd_oe_o && !de_oe_o && !oclk_oe_o));

    // R2
    single_odd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !two_pix_i |=> !odd_oe_o);

    // R3
    half_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_state == ST_HALF && full_pd_n_i) |=> pair_state == ST_IDLE);

    // R9
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !full_pd_n_i |=> ($stable(even_q) && $stable(pair_state)));

    // R7
    dual_noinv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_link_i && full_pd_n_i) |=> !inv_q);
endmodule

bind pixel_out_fmt pixel_out_fmt_chk #(.PIX_W(PIX_W), .CTL_W(CTL_W), .CTL1_IDX(CTL1_IDX)) chk_i (
    .clk(clk), .rst_n(rst_n), .two_pix_i(two_pix_i), .dual_link_i(dual_link_i),
    .out_pd_n_i(out_pd_n_i), .full_pd_n_i(full_pd_n_i),
    .even_oe_o(even_oe_o), .odd_oe_o(odd_oe_o), .de_oe_o(de_oe_o),
    .ctl_oe_o(ctl_oe_o), .oclk_oe_o(oclk_oe_o), .sync_oe_o(sync_oe_o),
    .pair_state(pair_state), .even_q(even_q), .inv_q(inv_q)
);

// File: tb/pixel_out_fmt_tb_top.sv
module pixel_out_fmt_tb_top;
    localparam int PW  = 24;
    localparam int CW  = 4;
    localparam int LIM = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] pix_i = '0;
    logic          de_i = 1'b0;
    logic [CW-1:0] ctl_i = '0;
    logic          two_pix_i = 1'b0, stag_n_i = 1'b1, clk_inv_i = 1'b0, dual_link_i = 1'b0;
    logic          out_pd_n_i = 1'b1, full_pd_n_i = 1'b1;
    logic [PW-1:0] even_o, odd_o;
    logic          de_o, oclk_o, sync_det_o, even_oe_o, odd_oe_o, de_oe_o, oclk_oe_o, sync_oe_o;
    logic [CW-1:0] ctl_o, ctl_oe_o;

    always #2 clk = ~clk;

    pixel_out_fmt dut_i (.*);

    // behavioural reference state
    bit            m_half;
    logic [PW-1:0] m_first, m_even, m_odd, m_oddneg;
    logic          m_de, m_inv, m_stag, m_deprev;
    logic [CW-1:0] m_ctl, m_ctl_oe;
    logic          m_ev_oe, m_odd_oe, m_de_oe, m_ck_oe, m_sy_oe;
    int            m_cnt;
    int            checks = 0, failures = 0;
    string         cur_req = "R1";

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_half = 0; m_first = '0; m_even = '0; m_odd = '0; m_oddneg = '0;
        m_de = 0; m_inv = 0; m_stag = 0; m_deprev = 0; m_ctl = '0; m_ctl_oe = '0;
        m_ev_oe = 0; m_odd_oe = 0; m_de_oe = 0; m_ck_oe = 0; m_sy_oe = 0; m_cnt = LIM;
    endtask

    task automatic model_edge();
        logic          drv;
        logic [PW-1:0] old_odd;
        old_odd = m_odd;
        drv = full_pd_n_i & out_pd_n_i;
        if (full_pd_n_i) begin
            m_ctl = ctl_i;
            if (!two_pix_i) begin
                m_half = 0; m_even = pix_i; m_de = de_i;
            end else if (m_half) begin
                m_half = 0; m_even = m_first; m_de = 1;
                if (de_i) m_odd = pix_i;
            end else begin
                m_de = 0;
                if (de_i) begin m_first = pix_i; m_half = 1; end
            end
            if (de_i != m_deprev) begin m_cnt = 0; m_deprev = de_i; end
            else if (m_cnt != LIM) m_cnt++;
            m_inv  = clk_inv_i & ~dual_link_i;
            m_stag = two_pix_i & ~stag_n_i;
        end
        m_oddneg = old_odd;
        m_ev_oe = drv; m_odd_oe = drv & two_pix_i; m_de_oe = drv; m_ck_oe = drv;
        m_sy_oe = full_pd_n_i;
        for (int i = 0; i < CW; i++) m_ctl_oe[i] = (i == 1) ? full_pd_n_i : drv;
    endtask

    task automatic compare();
        chk("even_o", 32'(even_o), m_ev_oe ? 32'(m_even) : 32'h0);
        chk("odd_o", 32'(odd_o), m_odd_oe ? 32'(m_stag ? m_oddneg : m_odd) : 32'h0);
        chk("de_o", 32'(de_o), 32'(m_de_oe & m_de));
        chk("ctl_o", 32'(ctl_o), 32'(m_ctl_oe & m_ctl));
        chk("oclk_o_high_phase", 32'(oclk_o), 32'(m_ck_oe & ~m_inv));
        chk("sync_det_o", 32'(sync_det_o), 32'(m_sy_oe & (m_cnt != LIM)));
        chk("oe_flags", {24'h0, even_oe_o, odd_oe_o, de_oe_o, oclk_oe_o, sync_oe_o, ctl_oe_o[2:0]},
            {24'h0, m_ev_oe, m_odd_oe, m_de_oe, m_ck_oe, m_sy_oe, m_ctl_oe[2:0]});
        chk("ctl_oe3", 32'(ctl_oe_o[3]), 32'(m_ctl_oe[3]));
    endtask

    task automatic step();
        @(posedge clk);
        if (!rst_n) model_reset(); else model_edge();
        #1;
        compare();
    endtask

    task automatic px(logic d, logic [PW-1:0] p, logic [CW-1:0] c);
        de_i = d; pix_i = p; ctl_i = c;
        step();
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        model_reset();
        // R1: reset state
        cur_req = "R1";
        step(); step(); step();
        rst_n = 1'b1;
        step();

        // R2 / R11: single-pixel mode
        cur_req = "R2";
        for (int i = 0; i < 6; i++) px(i != 2, 24'h100000 + 24'(i * 3), 4'(i));
        cur_req = "R11";
        for (int i = 0; i < 4; i++) px(1, 24'hA0A0A0 ^ 24'(i), 4'(15 - i));

        // R3: two-pixel pairs
        cur_req = "R3";
        two_pix_i = 1;
        for (int i = 0; i < 6; i++) px(1, 24'h200000 + 24'(i), 4'(i));
        px(0, 24'hDEAD00, 0); px(0, 24'hDEAD01, 0);

        // R4: odd count flush
        cur_req = "R4";
        for (int i = 0; i < 3; i++) px(1, 24'h300000 + 24'(i), 0);
        for (int i = 0; i < 3; i++) px(0, 24'hBAD000 + 24'(i), 0);

        // R5: stagger in two-pixel mode, then no effect in one-pixel mode
        cur_req = "R5";
        stag_n_i = 0;
        for (int i = 0; i < 8; i++) px(1, 24'h400000 + 24'(i * 17), 0);
        two_pix_i = 0;
        for (int i = 0; i < 3; i++) px(1, 24'h410000 + 24'(i), 0);
        two_pix_i = 1;
        for (int i = 0; i < 4; i++) px(1, 24'h420000 + 24'(i), 0);
        stag_n_i = 1;
        px(1, 24'h430000, 0); px(1, 24'h430001, 0);

        // R6: clock inversion
        cur_req = "R6";
        clk_inv_i = 1;
        for (int i = 0; i < 4; i++) px(1, 24'h500000 + 24'(i), 4'(i));
        // R7: inversion refused in dual-link
        cur_req = "R7";
        dual_link_i = 1;
        for (int i = 0; i < 4; i++) px(1, 24'h510000 + 24'(i), 0);
        dual_link_i = 0; clk_inv_i = 0;
        step();

        // R8: output power-down
        cur_req = "R8";
        out_pd_n_i = 0;
        for (int i = 0; i < 5; i++) px(1, 24'h600000 + 24'(i), 4'hF);
        out_pd_n_i = 1;
        for (int i = 0; i < 3; i++) px(1, 24'h610000 + 24'(i), 4'h5);

        // R9: full power-down freezes a pending half pair
        cur_req = "R9";
        px(0, 0, 0); px(0, 0, 0);
        px(1, 24'h700001, 4'h3);
        full_pd_n_i = 0;
        two_pix_i = 0; clk_inv_i = 1;
        for (int i = 0; i < 4; i++) px(i[0], 24'hFFFF00 + 24'(i), 4'hF);
        full_pd_n_i = 1; two_pix_i = 1; clk_inv_i = 0;
        px(1, 24'h700002, 4'h1);
        px(0, 0, 0); px(0, 0, 0);

        // R10: sync detect timeout and recovery
        cur_req = "R10";
        for (int i = 0; i < LIM + 4; i++) px(0, 0, 0);
        px(1, 24'h800000, 0);
        for (int i = 0; i < 3; i++) px(i[0], 24'h800001, 0);

        // R12: mode drop discards pending pixel
        cur_req = "R12";
        px(0, 0, 0);
        px(1, 24'h900001, 0);
        two_pix_i = 0;
        px(1, 24'h900002, 0);
        px(1, 24'h900003, 0);
        two_pix_i = 1;
        px(1, 24'h900004, 0); px(1, 24'h900005, 0); px(0, 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule